// File: doc/BRIEF.md
# Audio Channel Status Regenerator

This block produces the channel status bit stream for an eight-channel audio embedder. Each audio frame carries one status bit, shared by every sample in that frame across all eight channels. A status block spans 192 frames. The first 184 frames carry a 184-bit payload programmed by the host, which is 23 bytes. The last 8 frames carry a CRC byte that the block computes while the payload bits go out. A block-start flag is raised on the first frame of every block.

The host writes a new payload by presenting it on `status_i` and pulsing `apply_i`. The value goes into a shadow register and a pending flag rises. The block copies the shadow into the active register only on the first frame of the next block, and clears the pending flag on that same frame. When regeneration is disabled, the incoming status bit and block-start flag are passed straight through.

Top module: `cs_regen`

## Requirements
- R1: A frame counter advances by one on each cycle with `frame_i` high. It counts 0 to 191 and wraps to 0. It holds on all other cycles and resets to 0.
- R2: With `regen_en_i` high, `z_o` is 1 after the frame at count 0 and 0 after every other frame.
- R3: With `regen_en_i` high, the frame at count k (0 to 183) emits bit k of the active payload on `cs_o`. Vector bit 8n+j is bit j of byte n, so bytes go out in order from byte 0, each least significant bit first.
- R4: The frames at counts 184 to 191 emit the CRC, least significant bit first. The CRC uses x^8+x^4+x^3+x^2+1 in reflected form (0xB8) and starts from 0xFF. It is fed the 184 payload bits in emission order: fb = crc[0]^bit, then crc = (crc>>1) ^ (fb ? 0xB8 : 0).
- R5: A cycle with `apply_i` high loads `status_i` into the shadow register. `pend_o` reads 1 from the next cycle on.
- R6: `pend_o` stays 1 until the next frame at count 0. On that frame the shadow becomes the active payload, `pend_o` clears, and that frame already emits the new data. The active payload never changes on any other frame.
- R7: If `apply_i` is high on the same cycle as a frame at count 0, the new value is captured but the swap is deferred to the following block. `pend_o` stays 1 and the block emits the old payload.
- R8: With `regen_en_i` low, each frame copies `cs_i` to `cs_o` and `z_i` to `z_o`.
- R9: `cs_o` and `z_o` change only on cycles with `frame_i` high.
- R10: Reset leaves `cs_o`, `z_o` and `pend_o` at 0 and the active payload at all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per audio frame |
| regen_en_i | input | 1 | Regeneration enable; low selects pass-through |
| apply_i | input | 1 | Host request to take `status_i` |
| status_i | input | 184 | Host status payload, bit 8n+j is byte n bit j |
| cs_i | input | 1 | Incoming channel status bit |
| z_i | input | 1 | Incoming block-start flag |
| cs_o | output | 1 | Channel status bit for the current frame |
| z_o | output | 1 | Block-start flag for the current frame |
| pend_o | output | 1 | Host update waiting for a block boundary |

## Verification
The assertions assume that `frame_i` is a single-cycle strobe. They also assume that `cs_i` and `z_i` are valid on the strobe cycle, and that `status_i` is valid whenever `apply_i` is high. The stimulus always raises `frame_i` for exactly one cycle with at least one idle cycle between frames. It changes the data inputs only at falling edges and holds `status_i` steady while `apply_i` is high. Host requests are placed in mid-block, between frames, and exactly on a block-start frame, so that both the swap path and the deferral path are covered.

// File: rtl/cs_regen_pkg.sv
package cs_regen_pkg;
  localparam int unsigned BLOCK_FRAMES = 192;
  localparam int unsigned CRC_W        = 8;
  localparam int unsigned PAYLOAD_W    = BLOCK_FRAMES - CRC_W;
  localparam int unsigned CNT_W        = $clog2(BLOCK_FRAMES);
  localparam logic [CRC_W-1:0] CRC_POLY_REF = 8'hB8;
  localparam logic [CRC_W-1:0] CRC_SEED     = 8'hFF;

  // reflected serial step, data bit enters at LSB side
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REF : '0);
  endfunction
endpackage

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned CNT_W  = $clog2(FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             first_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (frame_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign first_o = (cnt_q == '0);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R1
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && cnt_q == LAST |=> cnt_q == '0); // R1
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/cs_status_buf.sv
module cs_status_buf #(
  parameter int unsigned W = 184
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         apply_i,
  input  logic [W-1:0] data_i,
  input  logic         boundary_i,
  output logic [W-1:0] word_o,
  output logic         pend_o
);
  logic [W-1:0] shadow_q, active_q;
  logic         pend_q, swap;

  // a request arriving on the boundary wins; swap waits a block
  assign swap = boundary_i && pend_q && !apply_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (apply_i) begin
        shadow_q <= data_i;
        pend_q   <= 1'b1;
      end else if (swap) begin
        pend_q   <= 1'b0;
      end
      if (swap) active_q <= shadow_q;
    end
  end

  assign word_o = swap ? shadow_q : active_q;
  assign pend_o = pend_q;

  AST_APPLY_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> pend_q); // R5
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !boundary_i |=> pend_q); // R6
  AST_ACTIVE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(active_q)); // R6
  AST_APPLY_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && apply_i |=> $stable(active_q) && pend_q); // R7
endmodule

// File: rtl/cs_crc_acc.sv
module cs_crc_acc
  import cs_regen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             first_i,
  input  logic             data_phase_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= CRC_SEED;
    else if (frame_i) begin
      if (first_i)           crc_q <= crc_step(CRC_SEED, bit_i);
      else if (data_phase_i) crc_q <= crc_step(crc_q, bit_i);
    end
  end

  assign crc_o = crc_q;

  AST_CRC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(crc_q)); // R4
  AST_CRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && !data_phase_i |=> $stable(crc_q)); // R4
endmodule

// File: rtl/cs_regen.sv
module cs_regen
  import cs_regen_pkg::*;
#(
  parameter int unsigned FRAMES = BLOCK_FRAMES,
  parameter int unsigned PAY_W  = PAYLOAD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             regen_en_i,
  input  logic             apply_i,
  input  logic [PAY_W-1:0] status_i,
  input  logic             cs_i,
  input  logic             z_i,
  output logic             cs_o,
  output logic             z_o,
  output logic             pend_o
);
  localparam int unsigned CW     = $clog2(FRAMES);
  localparam int unsigned PIDX_W = $clog2(PAY_W);
  localparam int unsigned CIDX_W = $clog2(CRC_W);
  localparam logic [CW-1:0] DATA_END = CW'(PAY_W);

  logic [CW-1:0]    cnt;
  logic             first, boundary, data_phase, gen_bit, pay_bit;
  logic [PAY_W-1:0] word;
  logic [CRC_W-1:0] crc;
  logic [PIDX_W-1:0] pidx;
  logic [CIDX_W-1:0] cidx;
  logic             cs_q, z_q;

  cs_frame_ctr #(.FRAMES(FRAMES), .CNT_W(CW)) u_ctr (
    .clk_i, .rst_ni, .frame_i, .cnt_o(cnt), .first_o(first)
  );

  assign boundary   = frame_i && first;
  assign data_phase = cnt < DATA_END;

  cs_status_buf #(.W(PAY_W)) u_buf (
    .clk_i, .rst_ni, .apply_i, .data_i(status_i),
    .boundary_i(boundary), .word_o(word), .pend_o(pend_o)
  );

  assign pidx    = PIDX_W'(cnt);
  assign cidx    = CIDX_W'(cnt - DATA_END);
  assign pay_bit = word[pidx];
  assign gen_bit = data_phase ? pay_bit : crc[cidx];

  cs_crc_acc u_crc (
    .clk_i, .rst_ni, .frame_i, .first_i(first),
    .data_phase_i(data_phase), .bit_i(pay_bit), .crc_o(crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      z_q  <= 1'b0;
    end else if (frame_i) begin
      cs_q <= regen_en_i ? gen_bit : cs_i;
      z_q  <= regen_en_i ? first   : z_i;
    end
  end

  assign cs_o = cs_q;
  assign z_o  = z_q;

  AST_Z_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regen_en_i && frame_i && cnt == '0 |=> z_o); // R2
  AST_Z_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regen_en_i && frame_i && cnt != '0 |=> !z_o); // R2
  AST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regen_en_i && frame_i |=> cs_o == $past(cs_i) && z_o == $past(z_i)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cs_o) && $stable(z_o)); // R9
endmodule

// File: tb/cs_regen_test.sv
module cs_regen_test;
  localparam int PW = 184;
  localparam int NF = 192;

  logic clk = 0, rst_ni = 0;
  logic frame_i = 0, regen_en_i = 0, apply_i = 0, cs_i = 0, z_i = 0;
  logic [PW-1:0] status_i = '0;
  logic cs_o, z_o, pend_o;

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] m_act = '0, m_shd = '0;
  logic m_pend = 0;
  int   fidx = 0;
  logic [7:0] m_crc;

  always #2 clk = ~clk;

  cs_regen uut (.clk_i(clk), .rst_ni, .frame_i, .regen_en_i, .apply_i,
                .status_i, .cs_i, .z_i, .cs_o, .z_o, .pend_o);

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] calc_crc(input logic [PW-1:0] d);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < PW; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]} ^ (fb ? 8'hB8 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [PW-1:0] pat(input int kind, input logic [31:0] seed);
    logic [PW-1:0] v = '0;
    logic [31:0] s = seed;
    for (int i = 0; i < PW; i++) begin
      case (kind)
        0: v[i] = 1'b0;
        1: v[i] = 1'b1;
        2: v[i] = i[0];
        default: begin
          s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
          v[i] = s[3];
        end
      endcase
    end
    return v;
  endfunction

  task automatic do_apply(input logic [PW-1:0] d);
    @(negedge clk);
    apply_i = 1; status_i = d;
    @(negedge clk);
    apply_i = 0;
    m_shd = d; m_pend = 1;
    chk("R5 pend after apply", {31'b0, pend_o}, 1);
  endtask

  // one frame; optional apply on the same cycle; check outputs after it
  task automatic do_frame(input logic ap, input logic [PW-1:0] d, input logic full);
    logic eb, ez;
    @(negedge clk);
    frame_i = 1; cs_i = $urandom_range(0, 1); z_i = $urandom_range(0, 1);
    apply_i = ap; if (ap) status_i = d;
    if (ap) begin m_shd = d; m_pend = 1; end
    else if (fidx == 0 && m_pend) begin m_act = m_shd; m_pend = 0; end
    if (fidx == 0) m_crc = calc_crc(m_act);
    eb = (fidx < PW) ? m_act[fidx] : m_crc[fidx - PW];
    ez = (fidx == 0);
    if (!regen_en_i) begin eb = cs_i; ez = z_i; end
    @(negedge clk);
    frame_i = 0; apply_i = 0;
    if (full || fidx == 0) begin
      if (!regen_en_i)      chk("R8 pass-through cs", {31'b0, cs_o}, {31'b0, eb});
      else if (fidx < PW)   chk("R3 payload bit", {31'b0, cs_o}, {31'b0, eb});
      else                  chk("R4 crc bit", {31'b0, cs_o}, {31'b0, eb});
      if (!regen_en_i)      chk("R8 pass-through z", {31'b0, z_o}, {31'b0, ez});
      else                  chk("R2 z flag", {31'b0, z_o}, {31'b0, ez});
      chk("R6 pend tracking", {31'b0, pend_o}, {31'b0, m_pend});
    end
    if (fidx == 5) begin
      cs_i = ~cs_i; z_i = ~z_i;
      @(negedge clk); @(negedge clk);
      chk("R9 cs hold", {31'b0, cs_o}, {31'b0, eb});
      chk("R9 z hold", {31'b0, z_o}, {31'b0, ez});
    end
    fidx = (fidx == NF - 1) ? 0 : fidx + 1;
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n; i++) do_frame(1'b0, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset cs", {31'b0, cs_o}, 0);
    chk("R10 reset z", {31'b0, z_o}, 0);
    chk("R10 reset pend", {31'b0, pend_o}, 0);
    rst_ni = 1;
    regen_en_i = 1;
    // reset payload of zeros: a full block with its crc (R10, R3, R4, R1)
    run_frames(NF);
    chk("R1 wrap to block start", fidx, 0);
    // several payload patterns, each applied between blocks
    for (int k = 1; k < 6; k++) begin
      do_apply(pat(k > 3 ? 3 : k, 32'h1234_5678 * k + 1));
      run_frames(NF);
    end
    // apply mid-block: pend stays, old data continues (R6)
    run_frames(50);
    do_apply(pat(3, 32'hCAFE_0001));
    run_frames(NF - 50);
    run_frames(NF);
    // apply on the block-start frame: deferred (R7)
    do_apply(pat(2, 0));
    run_frames(NF);
    do_frame(1'b1, pat(3, 32'h0BAD_F00D), 1'b1);
    chk("R7 pend kept after boundary apply", {31'b0, pend_o}, 1);
    run_frames(NF - 1);
    run_frames(NF);
    // pass-through (R8)
    regen_en_i = 0;
    run_frames(40);
    regen_en_i = 1;
    run_frames(NF - 40);
    run_frames(NF);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule